// File: doc/BRIEF.md
# USB Bus Suspend and Resume Controller

This block watches the USB line state and decides when the bus has gone quiet long enough to count as a suspend. When that happens it raises a status flag for the local microcontroller. Firmware then asks for the power-down state by setting a suspend control bit, which drives the low-power enable output. While in low power, the block watches the line with logic that needs no clock. Any departure from the idle state counts as a global resume, including a bus reset (SE0). On a resume the block records the event, clears the suspend control bit by itself and leaves low power.

Idle time is measured in millisecond ticks. Each tick is built by counting strobes from a free-running time base. Two interrupt lines are produced. One is the status interrupt: it is gated by a common status enable and by one enable per source. The other is a wake-source interrupt with its own enable. For remote wakeup, firmware clears the suspend bit and sets a wakeup bit, and the block then raises a request to drive resume signalling on the bus.

Top module: `usb_susp_ctrl`

## Requirements
- R1: After reset, `isr_o`, `wake_src_o`, `lowpwr_o`, `drv_resume_o`, `irq_stat_o` and `irq_wake_o` are all 0.
- R2: The line state is idle when `linestate_i` is 2'b01 (J). While the line is idle, every TICK_DIV strobes on `tbase_stb_i` make one tick. The suspend flag `isr_o[0]` is set on the strobe that completes tick IDLE_MS+1 of continuous idle.
- R3: Any line state other than J restarts the idle measurement from zero. The suspend flag is raised at most once for each unbroken idle period.
- R4: A pulse on `ctl_wr_i` loads `ctl_susp_i` into the suspend control bit and `ctl_rwake_i` into the wakeup bit. The suspend control bit appears on `lowpwr_o` on the next cycle.
- R5: While `lowpwr_o` is 1, a change of the line away from J (for example to K, 2'b10) is captured with no clock running. Once the clock runs again, within three cycles the block sets the resume flag `isr_o[1]` and the wake-source bit `wake_src_o`, and clears `lowpwr_o`.
- R6: A bus reset (SE0, 2'b00) that occurs while `lowpwr_o` is 1 is treated exactly like a resume.
- R7: `irq_stat_o` is 1 only when `en_stat_i` is 1 and at least one source is both flagged and enabled. The sources are suspend (`isr_o[0]` with `en_susp_i`) and resume (`isr_o[1]` with `en_res_i`).
- R8: `irq_wake_o` is 1 exactly when `wake_src_o` is 1 and `en_wake_i` is 1.
- R9: Status is cleared by writing a one. A 1 in `isr_clr_i[n]` clears `isr_o[n]`, and a 0 leaves that bit alone. `wake_clr_i` clears `wake_src_o`.
- R10: `drv_resume_o` is 1 exactly when the wakeup bit is set and the suspend control bit is clear.
- R11: Line activity, including SE0, while `lowpwr_o` is 0 sets neither `isr_o[1]` nor `wake_src_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; may be stopped in low power |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbase_stb_i | input | 1 | Free-running time-base strobe |
| linestate_i | input | 2 | Line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| ctl_wr_i | input | 1 | Firmware write strobe for the control bits |
| ctl_susp_i | input | 1 | Suspend control value to load |
| ctl_rwake_i | input | 1 | Remote wakeup value to load |
| isr_clr_i | input | 2 | Write-one-to-clear for `isr_o` |
| wake_clr_i | input | 1 | Write-one-to-clear for `wake_src_o` |
| en_susp_i | input | 1 | Enable for the suspend source |
| en_res_i | input | 1 | Enable for the resume source |
| en_stat_i | input | 1 | Common status interrupt enable |
| en_wake_i | input | 1 | Wake-source interrupt enable |
| isr_o | output | 2 | Status flags: [1] resume, [0] suspend |
| wake_src_o | output | 1 | Resume recorded as a wake source |
| lowpwr_o | output | 1 | Low-power enable |
| drv_resume_o | output | 1 | Request to drive resume signalling |
| irq_stat_o | output | 1 | Status interrupt |
| irq_wake_o | output | 1 | Wake-source interrupt |

## Verification
The hardest case is a resume that arrives while the interface clock is stopped. The bench gates its own clock off at a falling edge, moves the line to K or SE0 with no edges running, and checks that the outputs have not changed. It then restarts the clock and expects the resume to appear once the signal has passed through the synchroniser. Idle timing is checked on both sides of the threshold, and a single-cycle break in the idle period must push the flag later.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;

  typedef enum logic [1:0] {
    LS_SE0 = 2'b00,
    LS_J   = 2'b01,
    LS_K   = 2'b10,
    LS_SE1 = 2'b11
  } line_e;

  typedef struct packed {
    logic susp;
    logic rwake;
  } ctl_t;

  typedef struct packed {
    logic res;
    logic susp;
  } stat_t;

endpackage

// File: rtl/usb_susp_idle_timer.sv
module usb_susp_idle_timer #(
  parameter int TICK_DIV = 1000,
  parameter int IDLE_MS  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  input  logic idle_i,
  output logic susp_evt_o
);

  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int MW = $clog2(IDLE_MS + 2);
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [MW-1:0] MS_FIRE  = MW'(IDLE_MS);
  localparam logic [MW-1:0] MS_SAT   = MW'(IDLE_MS + 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [MW-1:0] ms_q, ms_d;
  logic          tick;

  always_comb begin
    tick  = idle_i & stb_i & (pre_q == PRE_LAST);
    pre_d = pre_q;
    ms_d  = ms_q;
    if (!idle_i) begin
      pre_d = '0;
      ms_d  = '0;
    end else if (stb_i) begin
      pre_d = tick ? '0 : pre_q + 1'b1;
      if (tick && (ms_q != MS_SAT)) begin
        ms_d = ms_q + 1'b1;
      end
    end
    susp_evt_o = tick & (ms_q == MS_FIRE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ms_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ms_q  <= ms_d;
    end
  end

endmodule

// File: rtl/usb_susp_wake_sync.sv
module usb_susp_wake_sync
  import usb_susp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed_i,
  input  logic [1:0] linestate_i,
  output logic       res_evt_o
);

  logic                   wake_act;
  logic                   wake_lat;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   edge_q;

  // Any departure from J (K or SE0) is a wake condition.
  assign wake_act = (linestate_i != LS_J);

  // Clockless capture: the line edge itself clocks the flag.
  always_ff @(posedge wake_act or negedge armed_i) begin
    if (!armed_i) begin
      wake_lat <= 1'b0;
    end else begin
      wake_lat <= 1'b1;
    end
  end

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= '0;
        end else begin
          sync_q <= {sync_q[SYNC_STAGES-2:0], wake_lat};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sync_q <= '0;
        end else begin
          sync_q <= wake_lat;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_q <= 1'b0;
    end else begin
      edge_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign res_evt_o = sync_q[SYNC_STAGES-1] & ~edge_q;

endmodule

// File: rtl/usb_susp_regs.sv
module usb_susp_regs
  import usb_susp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       susp_evt_i,
  input  logic       res_evt_i,
  input  logic       ctl_wr_i,
  input  logic       ctl_susp_i,
  input  logic       ctl_rwake_i,
  input  logic [1:0] isr_clr_i,
  input  logic       wake_clr_i,
  input  logic       en_susp_i,
  input  logic       en_res_i,
  input  logic       en_stat_i,
  input  logic       en_wake_i,
  output logic [1:0] isr_o,
  output logic       wake_src_o,
  output logic       lowpwr_o,
  output logic       drv_resume_o,
  output logic       irq_stat_o,
  output logic       irq_wake_o
);

  ctl_t  ctl_q, ctl_d;
  stat_t stat_q, stat_d;
  logic  wake_q, wake_d;
  logic  ctl_en;

  always_comb begin
    ctl_en = ctl_wr_i | res_evt_i;
    ctl_d  = ctl_q;
    if (ctl_wr_i) begin
      ctl_d.susp  = ctl_susp_i;
      ctl_d.rwake = ctl_rwake_i;
    end
    if (res_evt_i) begin
      ctl_d.susp = 1'b0;
    end
    stat_d.susp = susp_evt_i | (stat_q.susp & ~isr_clr_i[0]);
    stat_d.res  = res_evt_i  | (stat_q.res  & ~isr_clr_i[1]);
    wake_d      = res_evt_i  | (wake_q & ~wake_clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
    end else if (ctl_en) begin
      ctl_q <= ctl_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      wake_q <= 1'b0;
    end else begin
      stat_q <= stat_d;
      wake_q <= wake_d;
    end
  end

  assign isr_o        = stat_q;
  assign wake_src_o   = wake_q;
  assign lowpwr_o     = ctl_q.susp;
  assign drv_resume_o = ctl_q.rwake & ~ctl_q.susp;
  assign irq_stat_o   = en_stat_i & ((stat_q.susp & en_susp_i) | (stat_q.res & en_res_i));
  assign irq_wake_o   = wake_q & en_wake_i;

endmodule

// File: rtl/usb_susp_ctrl.sv
module usb_susp_ctrl
  import usb_susp_pkg::*;
#(
  parameter int TICK_DIV    = 1000,
  parameter int IDLE_MS     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tbase_stb_i,
  input  logic [1:0] linestate_i,
  input  logic       ctl_wr_i,
  input  logic       ctl_susp_i,
  input  logic       ctl_rwake_i,
  input  logic [1:0] isr_clr_i,
  input  logic       wake_clr_i,
  input  logic       en_susp_i,
  input  logic       en_res_i,
  input  logic       en_stat_i,
  input  logic       en_wake_i,
  output logic [1:0] isr_o,
  output logic       wake_src_o,
  output logic       lowpwr_o,
  output logic       drv_resume_o,
  output logic       irq_stat_o,
  output logic       irq_wake_o
);

  logic [1:0] rst_ff;
  logic       rst_sync_n;
  logic       susp_evt;
  logic       res_evt;
  logic       line_idle;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_ff <= 2'b00;
    end else begin
      rst_ff <= {rst_ff[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_ff[1];

  assign line_idle = (linestate_i == LS_J);

  usb_susp_idle_timer #(
    .TICK_DIV (TICK_DIV),
    .IDLE_MS  (IDLE_MS)
  ) u_idle (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .stb_i      (tbase_stb_i),
    .idle_i     (line_idle),
    .susp_evt_o (susp_evt)
  );

  usb_susp_wake_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_wake (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .armed_i     (lowpwr_o),
    .linestate_i (linestate_i),
    .res_evt_o   (res_evt)
  );

  usb_susp_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .susp_evt_i   (susp_evt),
    .res_evt_i    (res_evt),
    .ctl_wr_i     (ctl_wr_i),
    .ctl_susp_i   (ctl_susp_i),
    .ctl_rwake_i  (ctl_rwake_i),
    .isr_clr_i    (isr_clr_i),
    .wake_clr_i   (wake_clr_i),
    .en_susp_i    (en_susp_i),
    .en_res_i     (en_res_i),
    .en_stat_i    (en_stat_i),
    .en_wake_i    (en_wake_i),
    .isr_o        (isr_o),
    .wake_src_o   (wake_src_o),
    .lowpwr_o     (lowpwr_o),
    .drv_resume_o (drv_resume_o),
    .irq_stat_o   (irq_stat_o),
    .irq_wake_o   (irq_wake_o)
  );

endmodule

// File: rtl/usb_susp_ctrl_chk.sv
module usb_susp_ctrl_chk
  import usb_susp_pkg::*;
(
  input logic       clk,
  input logic       rst_sync_n,
  input logic [1:0] linestate_i,
  input logic       ctl_wr_i,
  input logic       ctl_susp_i,
  input logic [1:0] isr_clr_i,
  input logic       wake_clr_i,
  input logic       en_susp_i,
  input logic       en_res_i,
  input logic       en_stat_i,
  input logic       en_wake_i,
  input logic [1:0] isr_o,
  input logic       wake_src_o,
  input logic       lowpwr_o,
  input logic       drv_resume_o,
  input logic       irq_stat_o,
  input logic       irq_wake_o,
  input logic       res_evt
);

  assert_rise_on_idle_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(isr_o[0]) |-> ($past(linestate_i) == LS_J));

  assert_break_restarts_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (linestate_i != LS_J) |=> !$rose(isr_o[0]));

  assert_ctl_load_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctl_wr_i && !res_evt) |=> (lowpwr_o == $past(ctl_susp_i)));

  assert_resume_effects_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_evt |=> (!lowpwr_o && isr_o[1] && wake_src_o));

  assert_stat_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_stat_o |-> (en_stat_i && ((isr_o[0] && en_susp_i) || (isr_o[1] && en_res_i))));

  assert_wake_irq_gate_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    irq_wake_o |-> (wake_src_o && en_wake_i));

  assert_w1c_res_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (isr_clr_i[1] && !res_evt) |=> !isr_o[1]);

  assert_w1c_wake_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wake_clr_i && !res_evt) |=> !wake_src_o);

  assert_drive_awake_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    drv_resume_o |-> !lowpwr_o);

endmodule

bind usb_susp_ctrl usb_susp_ctrl_chk u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .linestate_i  (linestate_i),
  .ctl_wr_i     (ctl_wr_i),
  .ctl_susp_i   (ctl_susp_i),
  .isr_clr_i    (isr_clr_i),
  .wake_clr_i   (wake_clr_i),
  .en_susp_i    (en_susp_i),
  .en_res_i     (en_res_i),
  .en_stat_i    (en_stat_i),
  .en_wake_i    (en_wake_i),
  .isr_o        (isr_o),
  .wake_src_o   (wake_src_o),
  .lowpwr_o     (lowpwr_o),
  .drv_resume_o (drv_resume_o),
  .irq_stat_o   (irq_stat_o),
  .irq_wake_o   (irq_wake_o),
  .res_evt      (res_evt)
);

// File: tb/usb_susp_ctrl_bench.sv
`timescale 1ns/1ps
module usb_susp_ctrl_bench;

  localparam int TICK_DIV = 4;
  localparam int IDLE_MS  = 3;
  localparam logic [1:0] J   = 2'b01;
  localparam logic [1:0] K   = 2'b10;
  localparam logic [1:0] SE0 = 2'b00;

  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n;
  logic       tbase_stb_i;
  logic [1:0] linestate_i;
  logic       ctl_wr_i, ctl_susp_i, ctl_rwake_i;
  logic [1:0] isr_clr_i;
  logic       wake_clr_i;
  logic       en_susp_i, en_res_i, en_stat_i, en_wake_i;
  logic [1:0] isr_o;
  logic       wake_src_o, lowpwr_o, drv_resume_o, irq_stat_o, irq_wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always begin
    #2.5;
    if (clk_run) clk = ~clk;
  end

  usb_susp_ctrl #(
    .TICK_DIV (TICK_DIV),
    .IDLE_MS  (IDLE_MS)
  ) u_usb_susp_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .tbase_stb_i  (tbase_stb_i),
    .linestate_i  (linestate_i),
    .ctl_wr_i     (ctl_wr_i),
    .ctl_susp_i   (ctl_susp_i),
    .ctl_rwake_i  (ctl_rwake_i),
    .isr_clr_i    (isr_clr_i),
    .wake_clr_i   (wake_clr_i),
    .en_susp_i    (en_susp_i),
    .en_res_i     (en_res_i),
    .en_stat_i    (en_stat_i),
    .en_wake_i    (en_wake_i),
    .isr_o        (isr_o),
    .wake_src_o   (wake_src_o),
    .lowpwr_o     (lowpwr_o),
    .drv_resume_o (drv_resume_o),
    .irq_stat_o   (irq_stat_o),
    .irq_wake_o   (irq_wake_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fw_ctl(input logic s, input logic r);
    @(negedge clk);
    ctl_wr_i = 1'b1; ctl_susp_i = s; ctl_rwake_i = r;
    @(negedge clk);
    ctl_wr_i = 1'b0;
  endtask

  task automatic fw_clr(input logic [1:0] c, input logic w);
    @(negedge clk);
    isr_clr_i = c; wake_clr_i = w;
    @(negedge clk);
    isr_clr_i = 2'b00; wake_clr_i = 1'b0;
  endtask

  task automatic idle_for(input int n);
    @(negedge clk);
    linestate_i = J;
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 isr", isr_o, 0);
    check("R1 wake/lowpwr/drv", {wake_src_o, lowpwr_o, drv_resume_o}, 0);
    check("R1 irqs", {irq_stat_o, irq_wake_o}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_idle_suspend;
    @(negedge clk); linestate_i = K;
    fw_clr(2'b11, 1'b1);
    @(negedge clk); linestate_i = J;
    repeat (14) @(posedge clk);
    @(negedge clk);
    check("R2 before threshold", isr_o[0], 0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2 after threshold", isr_o[0], 1);
    fw_clr(2'b01, 1'b0);
    repeat (30) @(posedge clk);
    @(negedge clk);
    check("R3 once per idle period", isr_o[0], 0);
  endtask

  task automatic t_idle_break;
    @(negedge clk); linestate_i = K;
    fw_clr(2'b11, 1'b0);
    idle_for(10);
    linestate_i = K;
    @(negedge clk);
    idle_for(10);
    check("R3 break restarts count", isr_o[0], 0);
    repeat (8) @(posedge clk);
    @(negedge clk);
    check("R3 flag after full period", isr_o[0], 1);
  endtask

  task automatic t_mask_susp;
    en_stat_i = 1'b1; en_susp_i = 1'b1; en_res_i = 1'b0; #1;
    check("R7 suspend enabled", irq_stat_o, 1);
    en_susp_i = 1'b0; #1;
    check("R7 suspend source masked", irq_stat_o, 0);
    en_susp_i = 1'b1; en_stat_i = 1'b0; #1;
    check("R7 status enable masked", irq_stat_o, 0);
    en_susp_i = 1'b0;
  endtask

  task automatic t_w1c;
    fw_clr(2'b10, 1'b0);
    check("R9 zero bit keeps suspend flag", isr_o[0], 1);
    fw_clr(2'b01, 1'b0);
    check("R9 one bit clears suspend flag", isr_o[0], 0);
  endtask

  task automatic t_awake_activity;
    fw_clr(2'b11, 1'b1);
    @(negedge clk); linestate_i = K;
    @(negedge clk); linestate_i = SE0;
    @(negedge clk); linestate_i = J;
    repeat (6) @(negedge clk);
    check("R11 no resume when awake", {isr_o[1], wake_src_o}, 0);
    check("R11 lowpwr stays off", lowpwr_o, 0);
  endtask

  task automatic t_stopped_resume(input logic [1:0] ls, input string req);
    @(negedge clk); linestate_i = J;
    fw_clr(2'b11, 1'b1);
    fw_ctl(1'b1, 1'b0);
    check({req, "/R4 lowpwr on"}, lowpwr_o, 1);
    @(negedge clk);
    clk_run = 1'b0;
    #20;
    linestate_i = ls;
    #20;
    check({req, " held while clock stopped"}, {lowpwr_o, isr_o[1], wake_src_o}, 3'b100);
    clk_run = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({req, " resume flag"}, isr_o[1], 1);
    check({req, " wake source"}, wake_src_o, 1);
    check({req, " lowpwr cleared"}, lowpwr_o, 0);
    linestate_i = J;
  endtask

  task automatic t_mask_res;
    fw_clr(2'b01, 1'b0);
    en_stat_i = 1'b1; en_res_i = 1'b1; en_susp_i = 1'b0; #1;
    check("R7 resume enabled", irq_stat_o, 1);
    en_res_i = 1'b0; #1;
    check("R7 resume source masked", irq_stat_o, 0);
    en_wake_i = 1'b1; #1;
    check("R8 wake irq enabled", irq_wake_o, 1);
    en_wake_i = 1'b0; #1;
    check("R8 wake irq masked", irq_wake_o, 0);
    fw_clr(2'b00, 1'b1);
    check("R9 wake source cleared", wake_src_o, 0);
  endtask

  task automatic t_remote_wakeup;
    fw_ctl(1'b1, 1'b1);
    check("R10 held off in low power", drv_resume_o, 0);
    fw_ctl(1'b0, 1'b1);
    check("R10 drive request", drv_resume_o, 1);
    check("R10 lowpwr off", lowpwr_o, 0);
    fw_ctl(1'b0, 1'b0);
    check("R10 drive request ends", drv_resume_o, 0);
  endtask

  initial begin
    #500_000;
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tbase_stb_i = 1'b1; linestate_i = K;
    ctl_wr_i = 1'b0; ctl_susp_i = 1'b0; ctl_rwake_i = 1'b0;
    isr_clr_i = 2'b00; wake_clr_i = 1'b0;
    en_susp_i = 1'b0; en_res_i = 1'b0; en_stat_i = 1'b0; en_wake_i = 1'b0;
    t_reset();
    t_idle_suspend();
    t_idle_break();
    t_mask_susp();
    t_w1c();
    t_awake_activity();
    t_stopped_resume(K, "R5");
    t_mask_res();
    t_stopped_resume(SE0, "R6");
    t_remote_wakeup();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule